// File: doc/BRIEF.md
# AXI4 Per-Cycle Rule Monitor

This block is a passive, synthesizable observer placed beside one AXI4 interface. It watches the valid/ready handshakes and payloads of all five channels (write address, write data, write response, read address, read data) and turns the signal-local protocol rules into clocked comparators. Registered snapshots of the previous cycle take the place of simulator-only temporal operators. A bounded per-channel wait counter takes the place of an unbounded liveness check. The monitor drives no bus signal.

Every violation sets a sticky bit in a seven-bit rule vector. A four-bit code records which rule class was broken first. Both stay set until a synchronous clear pulse. The rule vector is never cleared by bus reset, so a fault seen just before or during reset survives it. The reset-behaviour rule is the one check that is live while the bus is in reset. Because of that, the flag registers carry no reset, and software or a test harness must pulse the clear input once after power-up.

Rule classes, given as bit index / code: reset-valid 0/1, valid-drop 1/2, payload-change 2/3, reserved-burst 3/4, oversize 4/5, wrap-length 5/6, stall-timeout 6/7. Code 0 means no violation has been recorded.

Top module: `axi_rule_monitor`

## Requirements
- R1: On any channel, if VALID was high and READY low at one clock edge and VALID is low at the next edge, bit 1 (valid-drop) is set.
- R2: On any channel, if VALID was high and READY low at one edge and VALID is still high at the next edge with any payload field changed, bit 2 (payload-change) is set. The payload fields are: address, length, size, burst, ID, protection, cache and lock on AW and AR; data, strobe and last on W; ID and response on B; data, response, last and ID on R.
- R3: A burst field of 2'b11 sampled with its address VALID high, on either AW or AR, sets bit 3 (reserved-burst).
- R4: A size field whose byte count (2 to the power of size) is greater than DATA_W/8, sampled with its address VALID high on AW or AR, sets bit 4 (oversize). A byte count equal to the bus width is legal.
- R5: A burst field of 2'b10 (wrapping) with a length field other than 1, 3, 7 or 15, sampled with its address VALID high on AW or AR, sets bit 5 (wrap-length).
- R6: While aresetn is low, rules R1 to R5 and R8 raise nothing. The handshake history is cleared by reset, so the first edge after reset is never compared against older data.
- R7: At every edge where aresetn is low and any of the five VALIDs is high, bit 0 (reset-valid) is set.
- R8: When a channel's VALID is high with READY low for MAX_WAIT consecutive edges, bit 6 (stall-timeout) is set at the MAX_WAIT-th such edge. A handshake or a low VALID restarts the count.
- R9: Flags and the code stay set until clear_i is sampled high. That edge zeroes both, even if a violation is present at the same edge. aresetn does not clear them.
- R10: first_err_o takes the code (bit index plus one) of the first violation seen while it is zero, and then holds that code. When several violations arrive at the same edge, the lowest code is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Bus clock |
| aresetn | input | 1 | Bus reset, active low |
| clear_i | input | 1 | Synchronous clear of flags and code |
| awvalid | input | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | input | ADDR_W | Write address |
| awlen | input | 8 | Write burst length minus one |
| awsize | input | 3 | Write beat size exponent |
| awburst | input | 2 | Write burst type |
| awid | input | ID_W | Write ID |
| awprot | input | 3 | Write protection |
| awcache | input | 4 | Write cache attributes |
| awlock | input | 1 | Write lock |
| wvalid | input | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte strobes |
| wlast | input | 1 | Last write beat |
| bvalid | input | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bid | input | ID_W | Write response ID |
| bresp | input | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| araddr | input | ADDR_W | Read address |
| arlen | input | 8 | Read burst length minus one |
| arsize | input | 3 | Read beat size exponent |
| arburst | input | 2 | Read burst type |
| arid | input | ID_W | Read ID |
| arprot | input | 3 | Read protection |
| arcache | input | 4 | Read cache attributes |
| arlock | input | 1 | Read lock |
| rvalid | input | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | input | DATA_W | Read data |
| rresp | input | 2 | Read response code |
| rlast | input | 1 | Last read beat |
| rid | input | ID_W | Read ID |
| err_flags_o | output | 7 | Sticky rule-class flags, bit index as listed above |
| first_err_o | output | 4 | Code of the earliest recorded violation |

## Verification
Every rule except the timeout is decided from the values sampled at one edge plus the previous edge's snapshot, so the matching flag and code become visible just after that same edge, one cycle after the offending inputs are applied. The timeout flag appears just after the MAX_WAIT-th consecutive stalled edge, and the bench runs with a small MAX_WAIT so the boundary fits inside the run. The bench drives inputs on falling edges and tags each expected item with the cycle number at which it is due. The scoreboard compares only on the falling edge of that cycle, one full rising edge after the stimulus, so each comparison lands exactly where the result first appears. A case that should raise nothing is checked at the same due cycle, against an all-zero flag vector.

// File: rtl/axi_mon_pkg.sv
package axi_mon_pkg;
  localparam int unsigned NUM_RULES = 7;
  localparam int unsigned CODE_W    = 4;

  // bit index of each rule class; code reported is index + 1
  localparam int unsigned IDX_RESET  = 0;
  localparam int unsigned IDX_DROP   = 1;
  localparam int unsigned IDX_CHANGE = 2;
  localparam int unsigned IDX_BURST  = 3;
  localparam int unsigned IDX_SIZE   = 4;
  localparam int unsigned IDX_WRAP   = 5;
  localparam int unsigned IDX_STALL  = 6;

  typedef logic [NUM_RULES-1:0] rule_vec_t;
  typedef logic [CODE_W-1:0]    rule_code_t;
endpackage

// File: rtl/mon_chan_watch.sv
// Per-channel handshake watcher: valid hold, payload hold, bounded stall.
module mon_chan_watch #(
  parameter int unsigned PW       = 8,
  parameter int unsigned MAX_WAIT = 1024
) (
  input  logic          aclk,
  input  logic          aresetn,
  input  logic          valid,
  input  logic          ready,
  input  logic [PW-1:0] payload,
  output logic          drop_v,
  output logic          change_v,
  output logic          stall_v
);
  localparam int unsigned CNT_W = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_WAIT - 1);

  logic             pend_q, pend_d;
  logic [PW-1:0]    snap_q;
  logic             snap_en;
  logic [CNT_W-1:0] wait_q, wait_d;

  always_comb begin
    pend_d  = valid & ~ready;
    snap_en = valid;
    if (valid && !ready) begin
      wait_d = (wait_q == LIMIT) ? wait_q : wait_q + CNT_W'(1);
    end else begin
      wait_d = '0;
    end
    drop_v   = pend_q & ~valid;
    change_v = pend_q & valid & (payload != snap_q);
    stall_v  = valid & ~ready & (wait_q == LIMIT);
  end

  always_ff @(posedge aclk or negedge aresetn) begin
    if (!aresetn) begin
      pend_q <= 1'b0;
      snap_q <= '0;
      wait_q <= '0;
    end else begin
      pend_q <= pend_d;
      wait_q <= wait_d;
      if (snap_en) snap_q <= payload;
    end
  end
endmodule

// File: rtl/mon_addr_rules.sv
// Encoding checks for one address channel (burst, size, wrap length).
module mon_addr_rules #(
  parameter int unsigned DATA_W = 32
) (
  input  logic       valid,
  input  logic [1:0] burst,
  input  logic [2:0] size,
  input  logic [7:0] len,
  output logic       burst_v,
  output logic       size_v,
  output logic       wrap_v
);
  localparam int unsigned BUS_BYTES = DATA_W / 8;

  logic        len_ok;
  logic [31:0] beat_bytes;

  always_comb begin
    beat_bytes = 32'd1 << size;
    len_ok     = (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
    burst_v    = valid & (burst == 2'b11);
    size_v     = valid & (beat_bytes > BUS_BYTES);
    wrap_v     = valid & (burst == 2'b10) & ~len_ok;
  end
endmodule

// File: rtl/mon_err_log.sv
// Sticky flag bank and first-violation code. Cleared only by clear_i so
// that violations seen during bus reset are kept.
module mon_err_log
  import axi_mon_pkg::*;
(
  input  logic       aclk,
  input  logic       clear_i,
  input  rule_vec_t  viol_i,
  output rule_vec_t  flags_o,
  output rule_code_t first_o
);
  rule_vec_t  flags_q, flags_d;
  rule_code_t first_q, first_d, low_code;

  always_comb begin
    low_code = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (viol_i[i]) low_code = CODE_W'(i + 1);
    end
    if (clear_i) begin
      flags_d = '0;
      first_d = '0;
    end else begin
      flags_d = flags_q | viol_i;
      first_d = (first_q == '0) ? low_code : first_q;
    end
  end

  always_ff @(posedge aclk) begin
    flags_q <= flags_d;
    first_q <= first_d;
  end

  assign flags_o = flags_q;
  assign first_o = first_q;
endmodule

// File: rtl/axi_rule_monitor.sv
module axi_rule_monitor
  import axi_mon_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ID_W     = 4,
  parameter int unsigned MAX_WAIT = 1024
) (
  input  logic                aclk,
  input  logic                aresetn,
  input  logic                clear_i,
  input  logic                awvalid,
  input  logic                awready,
  input  logic [ADDR_W-1:0]   awaddr,
  input  logic [7:0]          awlen,
  input  logic [2:0]          awsize,
  input  logic [1:0]          awburst,
  input  logic [ID_W-1:0]     awid,
  input  logic [2:0]          awprot,
  input  logic [3:0]          awcache,
  input  logic                awlock,
  input  logic                wvalid,
  input  logic                wready,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  input  logic                wlast,
  input  logic                bvalid,
  input  logic                bready,
  input  logic [ID_W-1:0]     bid,
  input  logic [1:0]          bresp,
  input  logic                arvalid,
  input  logic                arready,
  input  logic [ADDR_W-1:0]   araddr,
  input  logic [7:0]          arlen,
  input  logic [2:0]          arsize,
  input  logic [1:0]          arburst,
  input  logic [ID_W-1:0]     arid,
  input  logic [2:0]          arprot,
  input  logic [3:0]          arcache,
  input  logic                arlock,
  input  logic                rvalid,
  input  logic                rready,
  input  logic [DATA_W-1:0]   rdata,
  input  logic [1:0]          rresp,
  input  logic                rlast,
  input  logic [ID_W-1:0]     rid,
  output logic [6:0]          err_flags_o,
  output logic [3:0]          first_err_o
);
  localparam int unsigned A_PW = ADDR_W + 8 + 3 + 2 + ID_W + 3 + 4 + 1;
  localparam int unsigned W_PW = DATA_W + DATA_W / 8 + 1;
  localparam int unsigned B_PW = ID_W + 2;
  localparam int unsigned R_PW = DATA_W + 2 + 1 + ID_W;
  localparam int unsigned NCH  = 5;

  logic [NCH-1:0] drop_vec, change_vec, stall_vec;
  logic [1:0]     burst_vec, size_vec, wrap_vec;
  logic           any_valid;
  rule_vec_t      viol;

  mon_chan_watch #(.PW(A_PW), .MAX_WAIT(MAX_WAIT)) u_aw (
    .aclk(aclk), .aresetn(aresetn), .valid(awvalid), .ready(awready),
    .payload({awaddr, awlen, awsize, awburst, awid, awprot, awcache, awlock}),
    .drop_v(drop_vec[0]), .change_v(change_vec[0]), .stall_v(stall_vec[0]));

  mon_chan_watch #(.PW(W_PW), .MAX_WAIT(MAX_WAIT)) u_w (
    .aclk(aclk), .aresetn(aresetn), .valid(wvalid), .ready(wready),
    .payload({wdata, wstrb, wlast}),
    .drop_v(drop_vec[1]), .change_v(change_vec[1]), .stall_v(stall_vec[1]));

  mon_chan_watch #(.PW(B_PW), .MAX_WAIT(MAX_WAIT)) u_b (
    .aclk(aclk), .aresetn(aresetn), .valid(bvalid), .ready(bready),
    .payload({bid, bresp}),
    .drop_v(drop_vec[2]), .change_v(change_vec[2]), .stall_v(stall_vec[2]));

  mon_chan_watch #(.PW(A_PW), .MAX_WAIT(MAX_WAIT)) u_ar (
    .aclk(aclk), .aresetn(aresetn), .valid(arvalid), .ready(arready),
    .payload({araddr, arlen, arsize, arburst, arid, arprot, arcache, arlock}),
    .drop_v(drop_vec[3]), .change_v(change_vec[3]), .stall_v(stall_vec[3]));

  mon_chan_watch #(.PW(R_PW), .MAX_WAIT(MAX_WAIT)) u_r (
    .aclk(aclk), .aresetn(aresetn), .valid(rvalid), .ready(rready),
    .payload({rdata, rresp, rlast, rid}),
    .drop_v(drop_vec[4]), .change_v(change_vec[4]), .stall_v(stall_vec[4]));

  mon_addr_rules #(.DATA_W(DATA_W)) u_aw_enc (
    .valid(awvalid), .burst(awburst), .size(awsize), .len(awlen),
    .burst_v(burst_vec[0]), .size_v(size_vec[0]), .wrap_v(wrap_vec[0]));

  mon_addr_rules #(.DATA_W(DATA_W)) u_ar_enc (
    .valid(arvalid), .burst(arburst), .size(arsize), .len(arlen),
    .burst_v(burst_vec[1]), .size_v(size_vec[1]), .wrap_v(wrap_vec[1]));

  always_comb begin
    any_valid        = awvalid | wvalid | bvalid | arvalid | rvalid;
    viol             = '0;
    viol[IDX_RESET]  = ~aresetn & any_valid;
    viol[IDX_DROP]   = aresetn & (|drop_vec);
    viol[IDX_CHANGE] = aresetn & (|change_vec);
    viol[IDX_BURST]  = aresetn & (|burst_vec);
    viol[IDX_SIZE]   = aresetn & (|size_vec);
    viol[IDX_WRAP]   = aresetn & (|wrap_vec);
    viol[IDX_STALL]  = aresetn & (|stall_vec);
  end

  mon_err_log u_log (
    .aclk(aclk), .clear_i(clear_i), .viol_i(viol),
    .flags_o(err_flags_o), .first_o(first_err_o));
endmodule

// File: rtl/axi_rule_monitor_chk.sv
module axi_rule_monitor_chk
  import axi_mon_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              aclk,
  input logic              aresetn,
  input logic              clear_i,
  input logic              awvalid,
  input logic              awburst_rsv,
  input logic              wvalid,
  input logic              wready,
  input logic              bvalid,
  input logic              arvalid,
  input logic              rvalid,
  input logic              rready,
  input logic [DATA_W-1:0] rdata,
  input logic [6:0]        err_flags_o,
  input logic [3:0]        first_err_o
);
  logic [2:0] first_idx;
  assign first_idx = 3'(first_err_o - 4'd1);

  // R1: a dropped write-data VALID is flagged
  assert_w_drop_R1: assert property (@(posedge aclk) disable iff (!aresetn)
    ($past(aresetn) && $past(wvalid && !wready) && !wvalid && !clear_i)
    |=> err_flags_o[IDX_DROP]);

  // R2: read data changed while held is flagged
  assert_r_change_R2: assert property (@(posedge aclk) disable iff (!aresetn)
    ($past(aresetn) && $past(rvalid && !rready) && rvalid &&
     (rdata != $past(rdata)) && !clear_i)
    |=> err_flags_o[IDX_CHANGE]);

  // R3: reserved write burst type is flagged
  assert_aw_burst_R3: assert property (@(posedge aclk) disable iff (!aresetn)
    (awvalid && awburst_rsv && !clear_i) |=> err_flags_o[IDX_BURST]);

  // R7: deliberately not disabled by reset
  assert_reset_valid_R7: assert property (@(posedge aclk)
    (!aresetn && (awvalid || wvalid || bvalid || arvalid || rvalid) && !clear_i)
    |=> err_flags_o[IDX_RESET]);

  // R9: clear zeroes everything at the next edge
  assert_clear_R9: assert property (@(posedge aclk) disable iff (!aresetn)
    clear_i |=> (err_flags_o == '0 && first_err_o == '0));

  // R9: flags never fall without clear
  assert_sticky_R9: assert property (@(posedge aclk) disable iff (!aresetn)
    (!clear_i && $past(aresetn)) |=> ((err_flags_o & $past(err_flags_o)) == $past(err_flags_o)));

  // R10: a recorded code points at a set flag and is in range
  assert_code_flag_R10: assert property (@(posedge aclk) disable iff (!aresetn)
    (first_err_o != '0) |-> (first_err_o <= 4'(NUM_RULES) && err_flags_o[first_idx]));

  // R10: any set flag implies a recorded code
  assert_flag_code_R10: assert property (@(posedge aclk) disable iff (!aresetn)
    (err_flags_o != '0) |-> (first_err_o != '0));
endmodule

bind axi_rule_monitor axi_rule_monitor_chk #(.DATA_W(DATA_W)) u_chk (
  .aclk(aclk), .aresetn(aresetn), .clear_i(clear_i),
  .awvalid(awvalid), .awburst_rsv(awburst == 2'b11),
  .wvalid(wvalid), .wready(wready), .bvalid(bvalid), .arvalid(arvalid),
  .rvalid(rvalid), .rready(rready), .rdata(rdata),
  .err_flags_o(err_flags_o), .first_err_o(first_err_o));

// File: tb/test_axi_rule_monitor.sv
`timescale 1ns/1ps
module test_axi_rule_monitor;
  localparam int DW = 32, AW = 32, IW = 4, MW = 16;

  logic aclk, aresetn, clear_i;
  logic awvalid, awready, awlock; logic [AW-1:0] awaddr; logic [7:0] awlen;
  logic [2:0] awsize, awprot; logic [1:0] awburst; logic [IW-1:0] awid; logic [3:0] awcache;
  logic wvalid, wready, wlast; logic [DW-1:0] wdata; logic [DW/8-1:0] wstrb;
  logic bvalid, bready; logic [IW-1:0] bid; logic [1:0] bresp;
  logic arvalid, arready, arlock; logic [AW-1:0] araddr; logic [7:0] arlen;
  logic [2:0] arsize, arprot; logic [1:0] arburst; logic [IW-1:0] arid; logic [3:0] arcache;
  logic rvalid, rready, rlast; logic [DW-1:0] rdata; logic [1:0] rresp; logic [IW-1:0] rid;
  logic [6:0] err_flags_o; logic [3:0] first_err_o;

  axi_rule_monitor #(.DATA_W(DW), .ADDR_W(AW), .ID_W(IW), .MAX_WAIT(MW)) i_axi_rule_monitor (.*);

  typedef struct { int due; logic [6:0] err; logic [3:0] code; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  initial aclk = 1'b0;
  always #2.5 aclk = ~aclk;
  always @(posedge aclk) cyc <= cyc + 1;

  // scoreboard monitor: compare items when their cycle comes due
  always @(negedge aclk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (err_flags_o !== e.err || first_err_o !== e.code) begin
        errors++;
        $display("FAIL %s: flags=%b code=%0d expected flags=%b code=%0d",
                 e.tag, err_flags_o, first_err_o, e.err, e.code);
      end
    end
  end

  task automatic tick(); @(negedge aclk); endtask
  task automatic chk(string tag, logic [6:0] err, logic [3:0] code);
    exp_t e;
    e.due = cyc + 1; e.err = err; e.code = code; e.tag = tag;
    q.push_back(e);
  endtask
  task automatic idle();
    awvalid = 0; awready = 0; awaddr = 32'h1000; awlen = 0; awsize = 3'd2; awburst = 2'b01;
    awid = 1; awprot = 0; awcache = 0; awlock = 0;
    wvalid = 0; wready = 0; wdata = 0; wstrb = 4'hF; wlast = 1;
    bvalid = 0; bready = 0; bid = 0; bresp = 0;
    arvalid = 0; arready = 0; araddr = 32'h2000; arlen = 0; arsize = 3'd2; arburst = 2'b01;
    arid = 1; arprot = 0; arcache = 0; arlock = 0;
    rvalid = 0; rready = 0; rdata = 0; rresp = 0; rlast = 1; rid = 0;
  endtask
  task automatic do_clear(string tag);
    tick(); clear_i = 1; chk(tag, 7'h00, 4'd0);
    tick(); clear_i = 0;
  endtask

  initial begin
    idle(); aresetn = 0; clear_i = 1;
    // R9 reset state after clear
    tick(); chk("R9 clear during reset", 7'h00, 4'd0);
    tick(); clear_i = 0; chk("R9 reset state", 7'h00, 4'd0);
    // R7 and R6: illegal everything during reset, only reset-valid flagged
    tick(); awvalid = 1; awburst = 2'b11; awsize = 3'd7; chk("R7 R6 valid in reset", 7'h01, 4'd1);
    tick(); awvalid = 0; chk("R6 drop in reset ignored", 7'h01, 4'd1);
    tick(); aresetn = 1; awburst = 2'b01; awsize = 3'd2; chk("R9 flag survives reset", 7'h01, 4'd1);
    do_clear("R9 clear");
    // R1 R2 legal traffic
    tick(); awvalid = 1; chk("R1 legal wait", 7'h00, 4'd0);
    tick(); chk("R1 legal wait 2", 7'h00, 4'd0);
    tick(); awready = 1; wvalid = 1; wready = 1; wdata = 32'hA; chk("R1 accept", 7'h00, 4'd0);
    tick(); awvalid = 0; awready = 0; wdata = 32'hB; chk("R2 accepted beats may change", 7'h00, 4'd0);
    tick(); wvalid = 0; wready = 0; chk("R2 idle", 7'h00, 4'd0);
    // R1 drop on AW
    tick(); awvalid = 1; chk("R1 pend", 7'h00, 4'd0);
    tick(); awvalid = 0; chk("R1 aw drop", 7'h02, 4'd2);
    do_clear("R9 clear");
    // R2 R data change
    tick(); rvalid = 1; rdata = 32'h1111; chk("R2 pend", 7'h00, 4'd0);
    tick(); rdata = 32'h2222; chk("R2 rdata change", 7'h04, 4'd3);
    tick(); rready = 1; chk("R2 sticky", 7'h04, 4'd3);
    tick(); rvalid = 0; rready = 0; chk("R2 sticky 2", 7'h04, 4'd3);
    do_clear("R9 clear");
    // R2 AR id change
    tick(); arvalid = 1; arid = 1; chk("R2 ar pend", 7'h00, 4'd0);
    tick(); arid = 2; chk("R2 ar id change", 7'h04, 4'd3);
    tick(); arready = 1; chk("R2 ar accept", 7'h04, 4'd3);
    tick(); arvalid = 0; arready = 0; do_clear("R9 clear");
    // R3 AR reserved burst
    tick(); arvalid = 1; arready = 1; arburst = 2'b11; chk("R3 ar reserved burst", 7'h08, 4'd4);
    tick(); arvalid = 0; arready = 0; arburst = 2'b01; chk("R3 sticky", 7'h08, 4'd4);
    do_clear("R9 clear");
    // R4 size boundary
    tick(); awvalid = 1; awready = 1; awsize = 3'd2; chk("R4 full width legal", 7'h00, 4'd0);
    tick(); awsize = 3'd3; chk("R4 oversize", 7'h10, 4'd5);
    tick(); awvalid = 0; awready = 0; awsize = 3'd2; chk("R4 sticky", 7'h10, 4'd5);
    do_clear("R9 clear");
    // R5 wrap length
    tick(); awvalid = 1; awready = 1; awburst = 2'b10; awlen = 8'd1; chk("R5 wrap len 1 legal", 7'h00, 4'd0);
    tick(); awlen = 8'd15; chk("R5 wrap len 15 legal", 7'h00, 4'd0);
    tick(); awlen = 8'd2; chk("R5 wrap len 2 illegal", 7'h20, 4'd6);
    tick(); awvalid = 0; awready = 0; awburst = 2'b01; awlen = 0;
    do_clear("R9 clear");
    tick(); arvalid = 1; arready = 1; arburst = 2'b10; arlen = 8'd7; chk("R5 ar len 7 legal", 7'h00, 4'd0);
    tick(); arlen = 8'd31; chk("R5 ar len 31 illegal", 7'h20, 4'd6);
    tick(); arvalid = 0; arready = 0; arburst = 2'b01; arlen = 0;
    do_clear("R9 clear");
    // R10 same-cycle violations: lowest code kept
    tick(); wvalid = 1; chk("R10 pend", 7'h00, 4'd0);
    tick(); wvalid = 0; awvalid = 1; awready = 1; awburst = 2'b11; awsize = 3'd3;
    chk("R10 simultaneous", 7'h1A, 4'd2);
    tick(); idle(); chk("R10 sticky", 7'h1A, 4'd2);
    do_clear("R9 clear");
    // R10 earliest code kept over later lower code
    tick(); awvalid = 1; awready = 1; awsize = 3'd3; chk("R10 first oversize", 7'h10, 4'd5);
    tick(); awready = 0; awsize = 3'd2; chk("R10 pend", 7'h10, 4'd5);
    tick(); awvalid = 0; chk("R10 later drop keeps code", 7'h12, 4'd5);
    do_clear("R9 clear");
    // R8 count restarts on handshake
    for (int i = 0; i < MW - 1; i++) begin tick(); bvalid = 1; chk("R8 below limit", 7'h00, 4'd0); end
    tick(); bready = 1; chk("R8 handshake", 7'h00, 4'd0);
    for (int i = 0; i < MW - 1; i++) begin tick(); bready = 0; chk("R8 restarted count", 7'h00, 4'd0); end
    tick(); bready = 1; chk("R8 handshake 2", 7'h00, 4'd0);
    tick(); bvalid = 0; bready = 0; chk("R8 idle", 7'h00, 4'd0);
    // R8 timeout at MAX_WAIT-th stalled edge
    for (int i = 1; i <= MW; i++) begin
      tick(); bvalid = 1;
      if (i == MW) chk("R8 timeout", 7'h40, 4'd7); else chk("R8 pre-timeout", 7'h00, 4'd0);
    end
    tick(); bready = 1; chk("R8 sticky", 7'h40, 4'd7);
    tick(); bvalid = 0; bready = 0;
    do_clear("R9 clear");
    // R9 clear beats a simultaneous violation
    tick(); rvalid = 1; chk("R9 pend", 7'h00, 4'd0);
    tick(); rvalid = 0; clear_i = 1; chk("R9 clear wins", 7'h00, 4'd0);
    tick(); clear_i = 0; chk("R9 after clear", 7'h00, 4'd0);
    // R6 no stale compare across reset
    tick(); rvalid = 1; rdata = 32'h5; chk("R6 pend", 7'h00, 4'd0);
    tick(); rvalid = 0; aresetn = 0; chk("R6 in reset", 7'h00, 4'd0);
    tick(); aresetn = 1; rvalid = 1; rdata = 32'h6; chk("R6 first cycle after reset", 7'h00, 4'd0);
    tick(); rready = 1; chk("R6 accept", 7'h00, 4'd0);
    tick(); idle(); chk("R6 idle", 7'h00, 4'd0);
    tick(); tick();
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge aclk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule